// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Page Status Tracking

This block holds a small set of recent virtual-to-physical page translations so that most memory references skip the page table. It sits between the address-generation stage and a page table walker. Each cycle it may take one lookup: a virtual page number, the page offset and a flag that says whether the access is a store. When a stored tag equals the page number, the block answers combinationally in that same cycle with the physical address, built by placing the stored physical page number above the unchanged offset. When no tag matches, it raises a miss so the walker can fetch the translation and hand it back through a fill port.

Every slot carries a valid bit, a read-only bit, a dirty bit and a reference bit. Stores mark a writable page dirty, and a store to a read-only page is refused with a protection fault. Reference bits approximate recency: any hit or install sets them, and software pulses a clear input now and then to reset them all. A refill chooses its slot in this order: an empty slot, then an unreferenced slot, then a rotating pointer. On a process switch a flush input drops every translation at once.

Top module: `tlb_fa`

## Requirements
- R1: After reset no slot is valid, so every lookup reports a miss; with lk_valid low neither lk_hit nor lk_miss is asserted.
- R2: A lookup whose page number matches a valid slot asserts lk_hit in the same cycle, with lk_paddr equal to that slot's physical page number in the upper bits and lk_off in the low OFF_W bits.
- R3: A lookup that matches no valid slot asserts lk_miss and keeps lk_hit low; the two are never high together.
- R4: A fill with fill_fault low installs the translation; a fill with fill_fault high installs nothing, and the next lookup of that page still misses.
- R5: A freshly installed slot is clean. A store that hits a writable slot sets its dirty bit from the next cycle on; lk_dirty reports the dirty bit the hit slot holds at the time of the lookup.
- R6: A store that hits a read-only slot raises lk_prot_fault together with lk_hit and leaves the dirty bit clear; loads never raise lk_prot_fault.
- R7: A refill goes to the lowest-numbered invalid slot whenever one exists, even if an unreferenced valid slot is present.
- R8: With every slot valid, a refill goes to the lowest-numbered slot whose reference bit is clear. A hit or an install sets the slot's reference bit; ref_clear clears all of them.
- R9: With every slot valid and referenced, a refill goes to the slot named by a rotating pointer that starts at slot 0 after reset and advances by one, wrapping, after each refill it chose.
- R10: flush clears every valid bit at the clock edge. A lookup in the flush cycle reports a miss, and a fill in the flush cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_off | input | OFF_W | Page offset, passed through to the physical address |
| lk_store | input | 1 | The access is a store |
| lk_hit | output | 1 | Translation found this cycle |
| lk_miss | output | 1 | No translation found; request to the walker |
| lk_prot_fault | output | 1 | Store to a read-only page |
| lk_dirty | output | 1 | Dirty bit held by the hit slot |
| lk_paddr | output | PPN_W+OFF_W | Physical address of the hit |
| fill_valid | input | 1 | Walker returns a result this cycle |
| fill_vpn | input | VPN_W | Virtual page number of the returned result |
| fill_ppn | input | PPN_W | Physical page number of the returned result |
| fill_ro | input | 1 | Returned page is read-only |
| fill_fault | input | 1 | Walk ended in a page fault; nothing is installed |
| flush | input | 1 | Process switch: drop every translation |
| ref_clear | input | 1 | Clear all reference bits |

## Verification
The bench builds the block with ENTRIES set to 4 and the 20-bit page numbers and 12-bit offset of the defaults. Four slots fill after four installs, so a short run reaches the full buffer, where the choice between an unreferenced slot and the rotating pointer decides which translation is lost, and the pointer's wrap is within a few refills. Which slot a refill took is read back only by which earlier page stops hitting.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Source of the slot picked for a refill, in order of preference.
  typedef enum logic [1:0] {
    PICK_FREE   = 2'd0,
    PICK_COLD   = 2'd1,
    PICK_ROTATE = 2'd2
  } pick_src_e;

endpackage

// File: rtl/tlb_entry.sv
module tlb_entry #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             ref_clr,
  input  logic             acc_sel,
  input  logic             acc_dirty,
  input  logic             fill_sel,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_ro,
  output logic             e_valid,
  output logic             e_ref,
  output logic             e_dirty,
  output logic             e_ro,
  output logic [VPN_W-1:0] e_tag,
  output logic [PPN_W-1:0] e_ppn
);

  logic             valid_q, valid_n;
  logic             ref_q, ref_n;
  logic             dirty_q, dirty_n;
  logic             ro_q, ro_n;
  logic [VPN_W-1:0] tag_q;
  logic [PPN_W-1:0] ppn_q;

  // Priority, lowest to highest: access, install, reference clear, flush.
  always_comb begin
    valid_n = valid_q;
    ref_n   = ref_q;
    dirty_n = dirty_q;
    ro_n    = ro_q;
    if (acc_sel) begin
      ref_n = 1'b1;
      if (acc_dirty) dirty_n = 1'b1;
    end
    if (fill_sel) begin
      valid_n = 1'b1;
      ref_n   = 1'b1;
      dirty_n = 1'b0;
      ro_n    = fill_ro;
    end
    if (ref_clr) ref_n = 1'b0;
    if (flush) valid_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ref_q   <= 1'b0;
      dirty_q <= 1'b0;
      ro_q    <= 1'b0;
    end else begin
      valid_q <= valid_n;
      ref_q   <= ref_n;
      dirty_q <= dirty_n;
      ro_q    <= ro_n;
    end
  end

  // Payload registers: no reset, written only on install.
  always_ff @(posedge clk) begin
    if (fill_sel) begin
      tag_q <= fill_vpn;
      ppn_q <= fill_ppn;
    end
  end

  assign e_valid = valid_q;
  assign e_ref   = ref_q;
  assign e_dirty = dirty_q;
  assign e_ro    = ro_q;
  assign e_tag   = tag_q;
  assign e_ppn   = ppn_q;

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [VPN_W-1:0]   tag_arr [ENTRIES],
  input  logic [VPN_W-1:0]   vpn,
  output logic [ENTRIES-1:0] hit_oh,
  output logic               hit_any,
  output logic [IDX_W-1:0]   hit_idx
);

  // One comparator per slot, all in parallel.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_oh[g] = valid_vec[g] && (tag_arr[g] == vpn);
  end

  assign hit_any = |hit_oh;

  always_comb begin
    hit_idx = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (hit_oh[k]) hit_idx = hit_idx | IDX_W'(k);
    end
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] ref_vec,
  input  logic               adv,
  output logic [IDX_W-1:0]   vic_idx
);

  logic             free_found, cold_found;
  logic [IDX_W-1:0] free_idx, cold_idx;
  logic [IDX_W-1:0] ptr_q, ptr_n;
  pick_src_e        src;

  // Lowest-numbered empty slot and lowest-numbered cold slot.
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    cold_found = 1'b0;
    cold_idx   = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (!valid_vec[k]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(k);
      end
      if (!ref_vec[k]) begin
        cold_found = 1'b1;
        cold_idx   = IDX_W'(k);
      end
    end
  end

  always_comb begin
    if (free_found)      src = PICK_FREE;
    else if (cold_found) src = PICK_COLD;
    else                 src = PICK_ROTATE;
  end

  always_comb begin
    unique case (src)
      PICK_FREE: vic_idx = free_idx;
      PICK_COLD: vic_idx = cold_idx;
      default:   vic_idx = ptr_q;
    endcase
  end

  always_comb begin
    ptr_n = ptr_q;
    if (adv && (src == PICK_ROTATE)) begin
      ptr_n = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [OFF_W-1:0] lk_off,
  input  logic             lk_store,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_prot_fault,
  output logic             lk_dirty,
  output logic [PA_W-1:0]  lk_paddr,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_ro,
  input  logic             fill_fault,
  input  logic             flush,
  input  logic             ref_clear
);

  // Reset: asserted asynchronously, released on the second clock edge.
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic [ENTRIES-1:0] valid_vec, ref_vec, dirty_vec, ro_vec;
  logic [ENTRIES-1:0] hit_oh, acc_sel, fill_sel;
  logic [VPN_W-1:0]   tag_arr [ENTRIES];
  logic [PPN_W-1:0]   ppn_arr [ENTRIES];
  logic               hit_any, fill_go, acc_dirty;
  logic [IDX_W-1:0]   hit_idx, vic_idx;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
    .valid_vec (valid_vec),
    .tag_arr   (tag_arr),
    .vpn       (lk_vpn),
    .hit_oh    (hit_oh),
    .hit_any   (hit_any),
    .hit_idx   (hit_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .valid_vec (valid_vec),
    .ref_vec   (ref_vec),
    .adv       (fill_go),
    .vic_idx   (vic_idx)
  );

  // Lookup side: flush in the same cycle turns a would-be hit into a miss.
  assign lk_hit        = lk_valid && !flush && hit_any;
  assign lk_miss       = lk_valid && !lk_hit;
  assign lk_prot_fault = lk_hit && lk_store && ro_vec[hit_idx];
  assign lk_dirty      = lk_hit && dirty_vec[hit_idx];
  assign lk_paddr      = lk_hit ? {ppn_arr[hit_idx], lk_off} : '0;
  assign acc_dirty     = lk_store && !ro_vec[hit_idx];

  // Install side: faulting walks and fills during a flush are dropped.
  assign fill_go = fill_valid && !fill_fault && !flush;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign acc_sel[g]  = lk_hit && hit_oh[g];
    assign fill_sel[g] = fill_go && (vic_idx == IDX_W'(g));

    tlb_entry #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_entry (
      .clk       (clk),
      .rst_n     (rst_s2_q),
      .flush     (flush),
      .ref_clr   (ref_clear),
      .acc_sel   (acc_sel[g]),
      .acc_dirty (acc_dirty),
      .fill_sel  (fill_sel[g]),
      .fill_vpn  (fill_vpn),
      .fill_ppn  (fill_ppn),
      .fill_ro   (fill_ro),
      .e_valid   (valid_vec[g]),
      .e_ref     (ref_vec[g]),
      .e_dirty   (dirty_vec[g]),
      .e_ro      (ro_vec[g]),
      .e_tag     (tag_arr[g]),
      .e_ppn     (ppn_arr[g])
    );
  end

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int VPN_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             lk_store,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_prot_fault,
  input logic             lk_dirty,
  input logic             fill_valid,
  input logic             flush
);

  // R1: no lookup, no answer
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss));

  // R3: hit and miss exclusive
  a_r3_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));

  // R6: a protection fault only comes with a store that hit
  a_r6_fault_on_store_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_prot_fault |-> (lk_hit && lk_store));

  // R10: flush masks the same-cycle hit
  a_r10_flush_masks_hit: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !lk_hit);

  // R10: nothing is valid the cycle after a flush
  a_r10_empty_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  // R5: a writable store hit leaves the page dirty for a repeat lookup
  a_r5_store_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_store && !lk_prot_fault && !fill_valid) |=>
      (!(lk_valid && lk_hit && (lk_vpn == $past(lk_vpn))) || lk_dirty));

endmodule

bind tlb_fa tlb_fa_chk #(.VPN_W(VPN_W)) u_chk (.*);

// File: tb/tb_tlb_fa.sv
`timescale 1ns/1ps
module tb_tlb_fa;

  localparam int ENTRIES = 4;
  localparam int VPN_W   = 20;
  localparam int PPN_W   = 20;
  localparam int OFF_W   = 12;
  localparam int PA_W    = PPN_W + OFF_W;

  localparam logic [1:0] OP_LK = 2'd0, OP_FL = 2'd1, OP_FLUSH = 2'd2, OP_RCLR = 2'd3;

  typedef struct packed {
    logic [1:0]       op;
    logic [VPN_W-1:0] vpn;
    logic [OFF_W-1:0] off;
    logic             st;
    logic [PPN_W-1:0] ppn;
    logic             ro;
    logic             flt;
    logic             ehit;
    logic             efault;
    logic             edirty;
    logic [3:0]       req;
  } vec_t;

  function automatic vec_t v_lk(logic [VPN_W-1:0] vpn, logic [OFF_W-1:0] off, logic st,
                                logic ehit, logic ef, logic ed, logic [PPN_W-1:0] eppn,
                                logic [3:0] req);
    return '{op: OP_LK, vpn: vpn, off: off, st: st, ppn: eppn, ro: 1'b0, flt: 1'b0,
             ehit: ehit, efault: ef, edirty: ed, req: req};
  endfunction

  function automatic vec_t v_fl(logic [VPN_W-1:0] vpn, logic [PPN_W-1:0] ppn, logic ro,
                                logic flt, logic [3:0] req);
    return '{op: OP_FL, vpn: vpn, off: '0, st: 1'b0, ppn: ppn, ro: ro, flt: flt,
             ehit: 1'b0, efault: 1'b0, edirty: 1'b0, req: req};
  endfunction

  function automatic vec_t v_ctl(logic [1:0] op, logic [3:0] req);
    return '{op: op, vpn: '0, off: '0, st: 1'b0, ppn: '0, ro: 1'b0, flt: 1'b0,
             ehit: 1'b0, efault: 1'b0, edirty: 1'b0, req: req};
  endfunction

  localparam logic [VPN_W-1:0] PA = 20'h00004, PB = 20'h00002, PC = 20'h00100,
    PD = 20'h00200, PE = 20'h00300, PF = 20'h00400, PG = 20'h00500, PH = 20'h00600;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    v_lk(PA, 12'h0F3, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0, 4'd1),       // R1 empty after reset
    v_fl(PA, 20'h020C0, 1'b0, 1'b0, 4'd4),                         // R4 install A in slot 0
    v_lk(PA, 12'h0F3, 1'b0, 1'b1, 1'b0, 1'b0, 20'h020C0, 4'd2),    // R2 hit, address assembly
    v_fl(PB, 20'h11111, 1'b0, 1'b1, 4'd4),                         // R4 faulting walk
    v_lk(PB, 12'h082, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0, 4'd4),        // R4 nothing installed
    v_fl(PB, 20'h11111, 1'b1, 1'b0, 4'd4),                         // read-only B in slot 1
    v_lk(PB, 12'h082, 1'b1, 1'b1, 1'b1, 1'b0, 20'h11111, 4'd6),    // R6 store faults
    v_lk(PB, 12'h082, 1'b0, 1'b1, 1'b0, 1'b0, 20'h11111, 4'd6),    // R6 still clean, load ok
    v_lk(PA, 12'h010, 1'b1, 1'b1, 1'b0, 1'b0, 20'h020C0, 4'd5),    // R5 first store, clean
    v_lk(PA, 12'h010, 1'b0, 1'b1, 1'b0, 1'b1, 20'h020C0, 4'd5),    // R5 now dirty
    v_fl(PC, 20'h22222, 1'b0, 1'b0, 4'd7),                         // slot 2
    v_fl(PD, 20'h33333, 1'b0, 1'b0, 4'd7),                         // slot 3, buffer full
    v_ctl(OP_RCLR, 4'd8),
    v_lk(PA, 12'h000, 1'b0, 1'b1, 1'b0, 1'b1, 20'h020C0, 4'd8),    // warm slot 0
    v_lk(PC, 12'h000, 1'b0, 1'b1, 1'b0, 1'b0, 20'h22222, 4'd8),    // warm slot 2
    v_fl(PE, 20'h44444, 1'b0, 1'b0, 4'd8),                         // R8 takes cold slot 1
    v_lk(PB, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0, 4'd8),        // R8 B evicted
    v_lk(PE, 12'h123, 1'b0, 1'b1, 1'b0, 1'b0, 20'h44444, 4'd8),
    v_fl(PF, 20'h55555, 1'b0, 1'b0, 4'd8),                         // R8 takes cold slot 3
    v_lk(PD, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0, 4'd8),        // R8 D evicted
    v_lk(PF, 12'hFFF, 1'b0, 1'b1, 1'b0, 1'b0, 20'h55555, 4'd8),
    v_fl(PG, 20'h66666, 1'b0, 1'b0, 4'd9),                         // R9 all warm, pointer 0
    v_lk(PA, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0, 4'd9),        // R9 A evicted
    v_lk(PG, 12'h001, 1'b0, 1'b1, 1'b0, 1'b0, 20'h66666, 4'd9),
    v_lk(PC, 12'h002, 1'b0, 1'b1, 1'b0, 1'b0, 20'h22222, 4'd9),
    v_fl(PH, 20'h77777, 1'b0, 1'b0, 4'd9),                         // R9 pointer now 1
    v_lk(PE, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0, 4'd9),        // R9 E evicted
    v_lk(PH, 12'h003, 1'b0, 1'b1, 1'b0, 1'b0, 20'h77777, 4'd9),
    v_lk(PF, 12'h004, 1'b0, 1'b1, 1'b0, 1'b0, 20'h55555, 4'd9),
    v_ctl(OP_FLUSH, 4'd10),
    v_lk(PG, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0, 4'd10),       // R10 gone after flush
    v_lk(PC, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0, 4'd10)
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             lk_valid, lk_store, lk_hit, lk_miss, lk_prot_fault, lk_dirty;
  logic [VPN_W-1:0] lk_vpn, fill_vpn;
  logic [OFF_W-1:0] lk_off;
  logic [PA_W-1:0]  lk_paddr;
  logic [PPN_W-1:0] fill_ppn;
  logic             fill_valid, fill_ro, fill_fault, flush, ref_clear;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tlb_fa #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_off(lk_off), .lk_store(lk_store),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_prot_fault(lk_prot_fault),
    .lk_dirty(lk_dirty), .lk_paddr(lk_paddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_ro(fill_ro), .fill_fault(fill_fault), .flush(flush), .ref_clear(ref_clear)
  );

  task automatic idle_inputs();
    lk_valid = 0; lk_vpn = '0; lk_off = '0; lk_store = 0;
    fill_valid = 0; fill_vpn = '0; fill_ppn = '0; fill_ro = 0; fill_fault = 0;
    flush = 0; ref_clear = 0;
  endtask

  // Compare the lookup outputs with an expectation; inputs driven already.
  task automatic expect_lk(string req, logic ehit, logic ef, logic ed,
                           logic [PPN_W-1:0] eppn);
    logic [PA_W-1:0] epa;
    epa = ehit ? {eppn, lk_off} : '0;
    checks++;
    if (lk_hit !== ehit || lk_miss !== (lk_valid && !ehit) || lk_prot_fault !== ef ||
        lk_dirty !== ed || lk_paddr !== epa) begin
      errors++;
      $display("FAIL %s vpn=%h: hit=%b miss=%b fault=%b dirty=%b pa=%h, expected hit=%b miss=%b fault=%b dirty=%b pa=%h",
               req, lk_vpn, lk_hit, lk_miss, lk_prot_fault, lk_dirty, lk_paddr,
               ehit, lk_valid && !ehit, ef, ed, epa);
    end
  endtask

  task automatic lookup(logic [VPN_W-1:0] vpn, logic st, string req, logic ehit,
                        logic ef, logic ed, logic [PPN_W-1:0] eppn);
    @(negedge clk);
    idle_inputs();
    lk_valid = 1; lk_vpn = vpn; lk_off = 12'h5A5; lk_store = st;
    #1 expect_lk(req, ehit, ef, ed, eppn);
  endtask

  task automatic fill(logic [VPN_W-1:0] vpn, logic [PPN_W-1:0] ppn);
    @(negedge clk);
    idle_inputs();
    fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn;
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);

    // R1 reset state: idle gives no answer, lookup misses
    @(negedge clk);
    #1 expect_lk("R1", 1'b0, 1'b0, 1'b0, '0);

    foreach (VEC[i]) begin
      @(negedge clk);
      idle_inputs();
      case (VEC[i].op)
        OP_LK: begin
          lk_valid = 1; lk_vpn = VEC[i].vpn; lk_off = VEC[i].off; lk_store = VEC[i].st;
        end
        OP_FL: begin
          fill_valid = 1; fill_vpn = VEC[i].vpn; fill_ppn = VEC[i].ppn;
          fill_ro = VEC[i].ro; fill_fault = VEC[i].flt;
        end
        OP_FLUSH: flush = 1;
        default:  ref_clear = 1;
      endcase
      if (VEC[i].op == OP_LK) begin
        #1 expect_lk($sformatf("R%0d", VEC[i].req), VEC[i].ehit, VEC[i].efault,
                     VEC[i].edirty, VEC[i].ppn);
      end
    end

    // R10: lookup during the flush cycle misses, fill during flush is dropped
    fill(PA, 20'h0ABCD);
    @(negedge clk);
    idle_inputs();
    lk_valid = 1; lk_vpn = PA; flush = 1;
    fill_valid = 1; fill_vpn = PB; fill_ppn = 20'h0BBBB;
    #1 expect_lk("R10", 1'b0, 1'b0, 1'b0, '0);
    lookup(PA, 1'b0, "R10", 1'b0, 1'b0, 1'b0, '0);
    lookup(PB, 1'b0, "R10", 1'b0, 1'b0, 1'b0, '0);

    // R7: invalid slots win over cold valid ones
    fill(PA, 20'h0A000);                    // slot 0
    fill(PB, 20'h0B000);                    // slot 1
    @(negedge clk); idle_inputs(); ref_clear = 1;
    fill(PC, 20'h0C000);                    // must go to slot 2
    fill(PD, 20'h0D000);                    // must go to slot 3
    lookup(PA, 1'b0, "R7", 1'b1, 1'b0, 1'b0, 20'h0A000);
    lookup(PB, 1'b0, "R7", 1'b1, 1'b0, 1'b0, 20'h0B000);
    lookup(PC, 1'b0, "R7", 1'b1, 1'b0, 1'b0, 20'h0C000);
    lookup(PD, 1'b0, "R7", 1'b1, 1'b0, 1'b0, 20'h0D000);

    // R8: after a clear, only A is touched, so B (slot 1) is the first cold slot
    @(negedge clk); idle_inputs(); ref_clear = 1;
    lookup(PA, 1'b0, "R8", 1'b1, 1'b0, 1'b0, 20'h0A000);
    fill(PE, 20'h0E000);
    lookup(PB, 1'b0, "R8", 1'b0, 1'b0, 1'b0, '0);
    lookup(PA, 1'b0, "R8", 1'b1, 1'b0, 1'b0, 20'h0A000);
    lookup(PE, 1'b1, "R5", 1'b1, 1'b0, 1'b0, 20'h0E000);  // R5 new install is clean

    @(negedge clk);
    idle_inputs();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule